// File: doc/BRIEF.md
# Interrupt Source Conditioner and Router

This block takes a group of external interrupt request lines, conditions each one according to a per-source mode, and merges the results onto four routed interrupt outputs. It also drives one global alert line. Each raw input first crosses into the block clock domain through a two-flop synchronizer. A source in level mode reports the synchronized input directly. A source in an edge mode captures a rising edge into a sticky status bit, which software clears by writing one. A source in second-edge mode also records a further rising edge that arrives while its status bit is still pending. That record goes into a separate second-edge status bit, and any such bit raises the global alert.

Software configures and services the block through a plain synchronous register bus. There are no back-pressure or valid/ready handshakes: a write takes effect at the clock edge where `bus_wr` is high, and reads are combinational from `bus_addr`. Each source owns a 4-bit configuration nibble holding a 2-bit mode and a 2-bit route. An enable bit per source masks its contribution to the routed outputs. The status register and second-edge register stay readable whatever the mask is.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads zero and all outputs are low. With all configuration at zero, every source is in level mode routed to output 0.
- R2: Mode 00 (level): the source's status bit equals its raw input delayed through two flops. Writing 1 to that status bit has no effect.
- R3: Mode 01 (single-edge): a rising edge on the synchronized input sets the status bit. Further edges while it is set change nothing, and the source's second-edge bit stays 0.
- R4: Mode 10 (second-edge): a rising edge while the status bit is already set sets the source's second-edge bit. Any set second-edge bit drives `irq_second` high. A single edge with nothing pending leaves the second-edge bit at 0.
- R5: Mode 11 (reserved) behaves exactly like single-edge mode.
- R6: Output `irq_route[n]` is the OR of (status AND enable) over all sources whose route field equals n. A source with its enable bit at 0 does not reach any output.
- R7: In the edge modes, writing 1 to a status or second-edge bit clears it. When an edge and a clearing write for the same bit meet in one cycle, the bit ends up set.
- R8: A configuration write that changes a source's mode clears that source's captured status and second-edge bits.
- R9: Register map, 32-bit data. Address 0 holds sources 7..0 and address 1 holds sources 15..8. Source k of a register uses bits [4k+3:4k+2] for the mode and bits [4k+1:4k] for the route. Address 2 is the enable register, address 3 is status (write-one-to-clear), and address 4 is second-edge status (write-one-to-clear). Bit i of registers 2 to 4 belongs to source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 16 | Unsynchronized interrupt request lines |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_route | output | 4 | Routed interrupt outputs |
| irq_second | output | 1 | Global second-edge alert |

## Verification
A wrong captured bit shows up on the routed output selected by that source's route field within the same cycle. The same error is visible in the status register at the next read. A missed or spurious second-edge capture therefore appears on `irq_second` one clock after the edge that reaches the status cell. That edge reaches the cell two clocks after the raw input rises. A wrong clearing priority or stale state left after a mode change appears in the status and second-edge registers on the first read after the write that caused it. The bench aligns a clearing write with the exact cycle in which a synchronized edge lands, so that a wrong set-versus-clear priority shows up.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    MD_LEVEL  = 2'b00,
    MD_SINGLE = 2'b01,
    MD_SECOND = 2'b10,
    MD_RSVD   = 2'b11
  } src_mode_e;

  localparam int NIBBLE_W    = 4;
  localparam int SRC_PER_REG = 8;
  localparam int ROUTE_W     = 2;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] sync,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync = sync_q;
  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_mode_e mode,
  input  logic      mode_chg,
  input  logic      sync,
  input  logic      rise,
  input  logic      clr_stat,
  input  logic      clr_sedge,
  output logic      status,
  output logic      cap_q,
  output logic      sedge_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      sedge_q <= 1'b0;
    end else if (mode_chg) begin
      cap_q   <= 1'b0;
      sedge_q <= 1'b0;
    end else begin
      case (mode)
        MD_LEVEL: begin
          cap_q   <= 1'b0;
          sedge_q <= 1'b0;
        end
        MD_SECOND: begin
          if (rise)          cap_q <= 1'b1;
          else if (clr_stat) cap_q <= 1'b0;
          if (rise && cap_q)  sedge_q <= 1'b1;
          else if (clr_sedge) sedge_q <= 1'b0;
        end
        default: begin
          if (rise)          cap_q <= 1'b1;
          else if (clr_stat) cap_q <= 1'b0;
          sedge_q <= 1'b0;
        end
      endcase
    end
  end

  assign status = (mode == MD_LEVEL) ? sync : cap_q;
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int N       = 16,
  parameter int ROUTE_W = 2,
  localparam int OUTS   = 1 << ROUTE_W
) (
  input  logic [N-1:0]         status,
  input  logic [N-1:0]         enable,
  input  logic [N*ROUTE_W-1:0] route_sel,
  output logic [OUTS-1:0]      out
);
  for (genvar o = 0; o < OUTS; o++) begin : g_out
    logic [N-1:0] hit;
    for (genvar k = 0; k < N; k++) begin : g_src
      assign hit[k] = status[k] & enable[k] &
                      (route_sel[k*ROUTE_W +: ROUTE_W] == ROUTE_W'(o));
    end
    assign out[o] = |hit;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  localparam int NUM_OUT = 1 << ROUTE_W,
  localparam int NUM_CFG = NUM_SRC / SRC_PER_REG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_raw,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_OUT-1:0] irq_route,
  output logic               irq_second
);
  localparam logic [ADDR_W-1:0] ADR_ENABLE = ADDR_W'(NUM_CFG);
  localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(NUM_CFG + 1);
  localparam logic [ADDR_W-1:0] ADR_SEDGE  = ADDR_W'(NUM_CFG + 2);

  logic [DATA_W-1:0]          cfg_q [NUM_CFG];
  logic [NUM_SRC-1:0]         en_q;
  logic [NUM_SRC-1:0]         sync, rise, status, cap_q, sedge_q, mode_chg;
  logic [NUM_SRC-1:0]         clr_stat, clr_sedge;
  logic [2*NUM_SRC-1:0]       mode_flat;
  logic [NUM_SRC*ROUTE_W-1:0] route_flat;

  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    cfg_q[r] <= '0;
      else if (bus_wr && bus_addr == ADDR_W'(r))     cfg_q[r] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               en_q <= '0;
    else if (bus_wr && bus_addr == ADR_ENABLE) en_q <= bus_wdata[NUM_SRC-1:0];
  end

  assign clr_stat  = (bus_wr && bus_addr == ADR_STATUS) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign clr_sedge = (bus_wr && bus_addr == ADR_SEDGE)  ? bus_wdata[NUM_SRC-1:0] : '0;

  irqc_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_raw), .sync(sync), .rise(rise)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam int REG = k / SRC_PER_REG;
    localparam int LSB = (k % SRC_PER_REG) * NIBBLE_W;
    assign mode_flat[2*k +: 2]             = cfg_q[REG][LSB + ROUTE_W +: 2];
    assign route_flat[k*ROUTE_W +: ROUTE_W] = cfg_q[REG][LSB +: ROUTE_W];
    assign mode_chg[k] = bus_wr && (bus_addr == ADDR_W'(REG)) &&
                         (bus_wdata[LSB + ROUTE_W +: 2] != cfg_q[REG][LSB + ROUTE_W +: 2]);

    irqc_src_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .mode(src_mode_e'(mode_flat[2*k +: 2])),
      .mode_chg(mode_chg[k]),
      .sync(sync[k]), .rise(rise[k]),
      .clr_stat(clr_stat[k]), .clr_sedge(clr_sedge[k]),
      .status(status[k]), .cap_q(cap_q[k]), .sedge_q(sedge_q[k])
    );
  end

  irqc_route #(.N(NUM_SRC), .ROUTE_W(ROUTE_W)) u_route (
    .status(status), .enable(en_q), .route_sel(route_flat), .out(irq_route)
  );

  assign irq_second = |sedge_q;

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_CFG; r++)
      if (bus_addr == ADDR_W'(r)) bus_rdata = cfg_q[r];
    if (bus_addr == ADR_ENABLE) bus_rdata = DATA_W'(en_q);
    if (bus_addr == ADR_STATUS) bus_rdata = DATA_W'(status);
    if (bus_addr == ADR_SEDGE)  bus_rdata = DATA_W'(sedge_q);
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N    = 16,
  parameter int OUTS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2*N-1:0] mode,
  input logic [N-1:0]  cap_q,
  input logic [N-1:0]  sedge_q,
  input logic [N-1:0]  enable,
  input logic [OUTS-1:0] route_out
);
  for (genvar k = 0; k < N; k++) begin : g_k
    p_level_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*k +: 2] == 2'b00) |-> (cap_q[k] == 1'b0 && sedge_q[k] == 1'b0));
    p_sedge_only_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*k +: 2] != 2'b10) |-> (sedge_q[k] == 1'b0));
    p_sedge_after_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sedge_q[k]) |-> $past(cap_q[k]));
    p_mode_change_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode[2*k +: 2]) != mode[2*k +: 2]) |-> (cap_q[k] == 1'b0 && sedge_q[k] == 1'b0));
  end

  p_quiet_when_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> (route_out == '0));
endmodule

bind irqc_top irqc_checker #(.N(NUM_SRC), .OUTS(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_flat), .cap_q(cap_q),
  .sedge_q(sedge_q), .enable(en_q), .route_out(irq_route)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          is_out;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_raw = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_route;
  logic        irq_second;

  int     n_checks = 0;
  int     n_fail = 0;
  bit     done = 1'b0;
  item_t  sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_route(irq_route), .irq_second(irq_second)
  );

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_out ? {27'd0, irq_second, irq_route} : bus_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic check_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.is_out = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic check_out(input logic [4:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_out = 1'b1; it.exp = {27'd0, e}; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic pulse(input int k);
    @(posedge clk); #1;
    irq_raw[k] = 1'b1;
    repeat (2) @(posedge clk); #1;
    irq_raw[k] = 1'b0;
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_out(5'b00000, "R1 outputs");
    for (int a = 0; a < 5; a++) check_reg(3'(a), 32'h0, "R1 register");

    bus_write(3'd2, 32'h0000_FFFF);

    // R2 level mode follows input, writes ignored
    @(posedge clk); #1 irq_raw[3] = 1'b1;
    settle();
    check_reg(3'd3, 32'h0000_0008, "R2 level status");
    check_out(5'b00001, "R2 level route0");
    bus_write(3'd3, 32'h0000_0008);
    check_reg(3'd3, 32'h0000_0008, "R2 write ignored");
    @(posedge clk); #1 irq_raw[3] = 1'b0;
    settle();
    check_reg(3'd3, 32'h0, "R2 level falls");

    // R9 layout, R6 routing
    bus_write(3'd0, 32'h0030_0060);
    check_reg(3'd0, 32'h0030_0060, "R9 cfg low readback");
    @(posedge clk); #1 irq_raw[5] = 1'b1;
    settle();
    check_out(5'b01000, "R6 source5 route3");
    @(posedge clk); #1 irq_raw[5] = 1'b0;
    settle();

    // R3 single-edge
    pulse(1);
    check_reg(3'd3, 32'h0000_0002, "R3 edge captured");
    check_out(5'b00100, "R3 source1 route2");
    pulse(1);
    check_reg(3'd4, 32'h0, "R3 no second edge");
    check_out(5'b00100, "R3 second pulse ignored");
    bus_write(3'd3, 32'h0000_0002);
    check_reg(3'd3, 32'h0, "R7 w1c status");
    check_out(5'b00000, "R7 output drops");

    // R6 enable masking
    bus_write(3'd2, 32'h0000_FFFD);
    pulse(1);
    check_reg(3'd3, 32'h0000_0002, "R6 masked status visible");
    check_out(5'b00000, "R6 masked output");
    bus_write(3'd2, 32'h0000_FFFF);
    check_out(5'b00100, "R6 unmasked output");
    bus_write(3'd3, 32'h0000_0002);

    // R4 second-edge
    bus_write(3'd1, 32'h0009_0000);
    check_reg(3'd1, 32'h0009_0000, "R9 cfg high readback");
    pulse(12);
    check_reg(3'd4, 32'h0, "R4 first edge no alert");
    check_out(5'b00010, "R4 source12 route1");
    pulse(12);
    check_reg(3'd4, 32'h0000_1000, "R4 second edge captured");
    check_out(5'b10010, "R4 alert high");
    bus_write(3'd4, 32'h0000_1000);
    check_out(5'b00010, "R7 w1c second edge");
    bus_write(3'd3, 32'h0000_1000);
    check_reg(3'd3, 32'h0, "R7 status cleared");
    pulse(12);
    check_reg(3'd4, 32'h0, "R4 edge with nothing pending");
    pulse(12);
    check_out(5'b10010, "R4 alert again");

    // R8 mode change clears
    bus_write(3'd1, 32'h0005_0000);
    check_reg(3'd3, 32'h0, "R8 status cleared");
    check_reg(3'd4, 32'h0, "R8 second edge cleared");
    check_out(5'b00000, "R8 outputs quiet");

    // R5 reserved acts as single-edge
    bus_write(3'd0, 32'h0030_006C);
    pulse(0);
    check_reg(3'd3, 32'h0000_0001, "R5 reserved captures");
    pulse(0);
    check_out(5'b00001, "R5 no alert");
    check_reg(3'd4, 32'h0, "R5 no second edge");

    // R7 set wins over clear in the same cycle
    @(posedge clk); #1 irq_raw[0] = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    bus_addr = 3'd3; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; irq_raw[0] = 1'b0;
    settle();
    check_reg(3'd3, 32'h0000_0001, "R7 set beats clear");
    bus_write(3'd3, 32'h1);
    check_reg(3'd3, 32'h0, "R7 plain clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule